// File: doc/BRIEF.md
# Wait-Extended External Bus Cycle Sequencer

This block runs a single external memory access as three timed phases: an address phase, a command phase and a recovery phase, all advancing on the bus clock. A host requests an access by raising `start_i` with a read/write selector while the block is idle. Each phase length is programmed, and reads and writes have separate command lengths.

The command phase can be stretched by an external device. A low level on the wait input holds the access in the command phase. The wait input is sampled on every rising edge. In synchronous mode, the sample taken at one edge is acted on at the next edge. In asynchronous mode, an extra synchronizer stage sits in the path, so the sample is acted on two edges later. The programmed command length is raised, when needed, to cover that delay.

On a read, the data bus is captured at the edge that ends the command phase. On a write, the output-drive enable covers the command and recovery phases. When recovery completes, a one-cycle done pulse is raised and the block returns to idle.

Top module: `xbus_cycle_seq`

## Requirements
- R1: After reset, with no request, `adv_o`, `rd_o`, `wr_o`, `wdata_oe_o`, `busy_o` and `done_o` are all low.
- R2: An accepted request (`start_i` high while idle) sets `adv_o` high for max(`addr_len_i`,1) cycles. These cycles start in the cycle after the accepting edge.
- R3: With wait held high, the command phase lasts the programmed length: `cmd_rd_len_i` for reads and `cmd_wr_len_i` for writes. The length is first raised to a minimum of 1 in synchronous mode (`async_i`=0) and 2 in asynchronous mode (`async_i`=1).
- R4: In synchronous mode, once the programmed command cycles are used up, the decision at each edge uses the wait sample from the previous edge. A low sample (`wait_n_i`=0) adds one command cycle, and a high sample ends the phase. The edge that ends the address phase also samples wait.
- R5: In asynchronous mode, the same decision uses the wait sample taken two edges earlier.
- R6: `rd_o` (read, `rw_i`=0) or `wr_o` (write, `rw_i`=1) is high in every command cycle, including extended ones. The two strobes are never high together.
- R7: On a read, `rdata_o` takes the value of `rdata_i` present at the edge that ends the command phase, and holds it afterwards.
- R8: On a write, `wdata_oe_o` is high in exactly the command and recovery cycles. On a read, it stays low.
- R9: The recovery phase lasts max(`rec_len_i`,1) cycles. In the following cycle, `done_o` is high for one cycle and `busy_o` is low.
- R10: `start_i` is ignored while an access is in progress: phase lengths and the strobe used are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Access request, taken only when idle |
| rw_i | input | 1 | 0 = read, 1 = write; latched on acceptance |
| async_i | input | 1 | Wait handling: 0 = synchronous, 1 = asynchronous; latched on acceptance |
| addr_len_i | input | CNT_W | Address phase cycles (0 treated as 1) |
| cmd_rd_len_i | input | CNT_W | Command cycles for reads |
| cmd_wr_len_i | input | CNT_W | Command cycles for writes |
| rec_len_i | input | CNT_W | Recovery cycles (0 treated as 1) |
| wait_n_i | input | 1 | External wait, low = extend |
| rdata_i | input | DATA_W | External read data bus |
| adv_o | output | 1 | Address phase strobe |
| rd_o | output | 1 | Read strobe during the command phase |
| wr_o | output | 1 | Write strobe during the command phase |
| wdata_oe_o | output | 1 | Write data drive enable |
| busy_o | output | 1 | An access is in progress |
| done_o | output | 1 | One-cycle pulse after recovery |
| rdata_o | output | DATA_W | Captured read data |

## Verification
The assertions check these properties on every cycle:
- the two strobes are never high at the same time;
- a strobe stays high while the command phase goes on;
- a low wait sample that reaches the decision point keeps the command phase running;
- the address strobe rises only from idle;
- `done_o` lasts exactly one cycle.

Only the bench scenarios can show the rest. These cover:
- the exact cycle counts of each phase;
- the clamping of short programmed lengths;
- the one-edge and two-edge wait delays against wait patterns driven edge by edge;
- which edge's data bus value is captured;
- that a request held high during an access changes nothing.

// File: rtl/xbus_pkg.sv
// Package: shared phase encoding for the external bus cycle sequencer.
// Assumes: one access in flight at a time.
package xbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_REC  = 2'd3
    } xbus_phase_e;

endpackage

// File: rtl/xbus_wait_pipe.sv
// Module: xbus_wait_pipe
// Samples the active-low wait pin on every clock edge through two stages.
// The decision value comes from stage one in synchronous mode and from
// stage two in asynchronous mode, which adds one synchronizer stage.
// Assumes: the mode select stays stable for the whole access.
// Stages reset to "not waiting".
module xbus_wait_pipe (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic wait_n_i,
    output logic go_o
);

    logic stage1_q;
    logic stage2_q;

    // Shift the pin sample through the two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b1;
            stage2_q <= 1'b1;
        end else begin
            stage1_q <= wait_n_i;
            stage2_q <= stage1_q;
        end
    end

    // Pick the stage that matches the mode's decision delay.
    always_comb begin
        go_o = async_i ? stage2_q : stage1_q;
    end

endmodule

// File: rtl/xbus_phase_timer.sv
// Module: xbus_phase_timer
// Down counter for phase lengths. A load sets the count to (length - 1),
// the count then falls to zero and holds there, and zero_o flags the last
// cycle of a phase.
// Assumes: the caller loads an already clamped value.
module xbus_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on a phase change, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag the final cycle of the current phase.
    always_comb begin
        zero_o = (cnt_q == '0);
    end

endmodule

// File: rtl/xbus_cycle_seq.sv
// Module: xbus_cycle_seq (top)
// Sequences one external access through address, command and recovery
// phases. The command phase holds its programmed length, then extends while
// the delayed wait sample is low. On a read, the data bus is captured when
// the command phase ends.
// Assumes: the length inputs are stable during an access. The read/write
// selector and the mode are latched when a request is accepted.
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rw_i,
    input  logic              async_i,
    input  logic [CNT_W-1:0]  addr_len_i,
    input  logic [CNT_W-1:0]  cmd_rd_len_i,
    input  logic [CNT_W-1:0]  cmd_wr_len_i,
    input  logic [CNT_W-1:0]  rec_len_i,
    input  logic              wait_n_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              adv_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              wdata_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [CNT_W-1:0] MIN_SYNC  = CNT_W'(1);
    localparam logic [CNT_W-1:0] MIN_ASYNC = CNT_W'(2);

    xbus_phase_e      state_q, state_d;
    logic             rw_q;
    logic             async_q;
    logic             done_q;
    logic [DATA_W-1:0] rdata_q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             cnt_zero;
    logic             wait_go;
    logic             capture;
    logic             finish;

    // Raise a length to a floor and return (length - 1) for the timer.
    function automatic logic [CNT_W-1:0] len_to_load(input logic [CNT_W-1:0] len,
                                                     input logic [CNT_W-1:0] floor_v);
        logic [CNT_W-1:0] eff;
        eff = (len < floor_v) ? floor_v : len;
        return eff - 1'b1;
    endfunction

    xbus_wait_pipe u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  (async_q),
        .wait_n_i (wait_n_i),
        .go_o     (wait_go)
    );

    xbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ld),
        .load_val_i (ld_val),
        .zero_o     (cnt_zero)
    );

    // Next phase, timer load and capture/finish decisions.
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        capture = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start_i) begin
                    state_d = PH_ADDR;
                    ld      = 1'b1;
                    ld_val  = len_to_load(addr_len_i, MIN_SYNC);
                end
            end
            PH_ADDR: begin
                if (cnt_zero) begin
                    state_d = PH_CMD;
                    ld      = 1'b1;
                    ld_val  = len_to_load(rw_q ? cmd_wr_len_i : cmd_rd_len_i,
                                          async_q ? MIN_ASYNC : MIN_SYNC);
                end
            end
            PH_CMD: begin
                if (cnt_zero && wait_go) begin
                    state_d = PH_REC;
                    ld      = 1'b1;
                    ld_val  = len_to_load(rec_len_i, MIN_SYNC);
                    capture = !rw_q;
                end
            end
            PH_REC: begin
                if (cnt_zero) begin
                    state_d = PH_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register and per-access latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            rw_q    <= 1'b0;
            async_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (state_q == PH_IDLE && start_i) begin
                rw_q    <= rw_i;
                async_q <= async_i;
            end
        end
    end

    // Read data capture at the edge that ends the command phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= rdata_i;
        end
    end

    // Output decode from the phase and the latched direction.
    always_comb begin
        adv_o      = (state_q == PH_ADDR);
        rd_o       = (state_q == PH_CMD) && !rw_q;
        wr_o       = (state_q == PH_CMD) && rw_q;
        wdata_oe_o = rw_q && (state_q == PH_CMD || state_q == PH_REC);
        busy_o     = (state_q != PH_IDLE);
        done_o     = done_q;
        rdata_o    = rdata_q;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o)); // R6

    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_CMD && !(cnt_zero && wait_go)) |=> (rd_o || wr_o)); // R6

    AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_CMD && cnt_zero && !wait_go) |=> (state_q == PH_CMD)); // R4

    AST_ADDR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adv_o) |-> ($past(state_q) == PH_IDLE)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

endmodule

// File: tb/xbus_cycle_seq_tb.sv
module xbus_cycle_seq_tb;

    localparam int CNT_W  = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              rw_i = 1'b0;
    logic              async_i = 1'b0;
    logic [CNT_W-1:0]  addr_len_i = '0;
    logic [CNT_W-1:0]  cmd_rd_len_i = '0;
    logic [CNT_W-1:0]  cmd_wr_len_i = '0;
    logic [CNT_W-1:0]  rec_len_i = '0;
    logic              wait_n_i = 1'b1;
    logic [DATA_W-1:0] rdata_i = '0;
    logic              adv_o, rd_o, wr_o, wdata_oe_o, busy_o, done_o;
    logic [DATA_W-1:0] rdata_o;

    int n_checks = 0;
    int n_fail   = 0;

    xbus_cycle_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rw_i(rw_i),
        .async_i(async_i), .addr_len_i(addr_len_i), .cmd_rd_len_i(cmd_rd_len_i),
        .cmd_wr_len_i(cmd_wr_len_i), .rec_len_i(rec_len_i), .wait_n_i(wait_n_i),
        .rdata_i(rdata_i), .adv_o(adv_o), .rd_o(rd_o), .wr_o(wr_o),
        .wdata_oe_o(wdata_oe_o), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    // Independent model: command cycles given the effective length, the
    // decision delay and the per-edge wait pattern (bit j = sample at the
    // j-th edge counted from the edge that ends the address phase).
    function automatic int model_cmd(input int ceff, input int dly, input logic [31:0] pat);
        for (int e = ceff; e < 32 + dly; e++) begin
            if (e - dly >= 32 || pat[e - dly]) return e;
        end
        return 32 + dly;
    endfunction

    // Run one access and check each phase length and the outputs.
    task automatic run_access(input string name, input bit wr, input bit asy,
                              input int a, input int cr, input int cw, input int r,
                              input logic [31:0] pat, input logic [DATA_W-1:0] data,
                              input bit hold_start);
        int aeff, ceff, cexp, reff, nend;
        int n_adv, n_strb, n_rec, n_wrong, n_oe, n;
        bit seen_done;
        aeff = (a < 1) ? 1 : a;
        reff = (r < 1) ? 1 : r;
        ceff = wr ? cw : cr;
        if (ceff < (asy ? 2 : 1)) ceff = asy ? 2 : 1;
        cexp = model_cmd(ceff, asy ? 2 : 1, pat);
        nend = aeff + cexp;
        n_adv = 0; n_strb = 0; n_rec = 0; n_wrong = 0; n_oe = 0;
        seen_done = 1'b0;
        @(negedge clk);
        rw_i = wr; async_i = asy;
        addr_len_i = CNT_W'(a); cmd_rd_len_i = CNT_W'(cr);
        cmd_wr_len_i = CNT_W'(cw); rec_len_i = CNT_W'(r);
        start_i = 1'b1; wait_n_i = 1'b1;
        @(negedge clk);
        if (!hold_start) start_i = 1'b0;
        else rw_i = ~wr;
        n = 1;
        while (!seen_done && n < 80) begin
            if (done_o) begin
                seen_done = 1'b1;
            end else begin
                if (adv_o) n_adv++;
                if (rd_o || wr_o) n_strb++;
                if (wr ? rd_o : wr_o) n_wrong++;
                if (busy_o && !adv_o && !rd_o && !wr_o) begin
                    n_rec++;
                    start_i = 1'b0;
                end
                if (wdata_oe_o) n_oe++;
                wait_n_i = (n - aeff < 0) ? 1'b1 : ((n - aeff >= 32) ? 1'b1 : pat[n - aeff]);
                rdata_i  = (n == nend) ? data : (32'hBAD0_0000 | 32'(n));
                @(negedge clk);
                n++;
            end
        end
        start_i = 1'b0;
        check(seen_done && !busy_o, {name, " R9 done with busy low"}, busy_o, 0);
        check(n_adv == aeff, {name, " R2 address cycles"}, n_adv, aeff);
        check(n_strb == cexp, {name, (asy ? " R5" : " R4"), " R3 command cycles"}, n_strb, cexp);
        check(n_wrong == 0, {name, " R6 wrong strobe"}, n_wrong, 0);
        check(n_rec == reff, {name, " R9 recovery cycles"}, n_rec, reff);
        check(n_oe == (wr ? cexp + reff : 0), {name, " R8 drive enable cycles"}, n_oe, wr ? cexp + reff : 0);
        if (!wr) check(rdata_o == data, {name, " R7 captured data"}, rdata_o, data);
        @(negedge clk);
        check(!done_o, {name, " R9 done one cycle"}, done_o, 0);
        if (hold_start) check(!busy_o, {name, " R10 no extra access"}, busy_o, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!adv_o && !rd_o && !wr_o && !wdata_oe_o && !busy_o && !done_o,
              "R1 outputs after reset",
              {adv_o, rd_o, wr_o, wdata_oe_o, busy_o, done_o}, 0);
    endtask

    task automatic t_plain();
        run_access("read_sync", 1'b0, 1'b0, 2, 3, 6, 2, 32'hFFFF_FFFF, 32'h1234_5678, 1'b0);
        run_access("write_sync", 1'b1, 1'b0, 1, 2, 5, 3, 32'hFFFF_FFFF, 32'h0, 1'b0);
    endtask

    task automatic t_trace();
        // Samples low, low, high from the edge ending the address phase.
        run_access("trace_sync", 1'b0, 1'b0, 1, 1, 4, 1, 32'hFFFF_FFFC, 32'hCAFE_F00D, 1'b0);
        run_access("wait_mid_sync", 1'b1, 1'b0, 2, 3, 2, 2, 32'hFFFF_FF0B, 32'h0, 1'b0);
    endtask

    task automatic t_async();
        run_access("async_read", 1'b0, 1'b1, 1, 2, 7, 1, 32'hFFFF_FFF8, 32'hA5A5_0001, 1'b0);
        run_access("async_write", 1'b1, 1'b1, 3, 1, 3, 2, 32'hFFFF_FFF6, 32'h0, 1'b0);
    endtask

    task automatic t_clamp();
        run_access("clamp_sync", 1'b0, 1'b0, 0, 0, 9, 0, 32'hFFFF_FFFF, 32'h0BAD_CAFE, 1'b0);
        run_access("clamp_async", 1'b0, 1'b1, 0, 1, 9, 0, 32'hFFFF_FFFF, 32'h7777_0002, 1'b0);
    endtask

    task automatic t_ignore_start();
        run_access("busy_start", 1'b0, 1'b0, 2, 2, 8, 2, 32'hFFFF_FFFD, 32'h5555_AAAA, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_trace();
        t_async();
        t_clamp();
        t_ignore_start();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule